// File: doc/BRIEF.md
# Thermometer-Coded Octal Token Counter

This block keeps a five-digit prepaid token count. Each digit is a unary field inside a bit-addressed map, and the number of ones in the field is the digit's value. The fields sit at bit addresses 65 to 103. The most significant digit (D4) has 7 bits and the four lower digits (D3 down to D0) have 8 bits each. A digit may therefore hold the value eight. The total is read as an octal number, so one count can have several encodings: 00500 and 00480 both stand for 320.

Three update requests are accepted, each tagged with a bit address. The first decrements the addressed digit. The second refills the next lower digit to eight. The third does both as one update. A request does not change the stored fields directly. It computes the new field values into a shadow copy and marks an update as pending. A commit strobe copies the shadow into the fields in a single cycle. An abort strobe, which stands in for power lost during programming, throws the shadow away. Either every field of an update changes or none does.

The block also has a registered serial-readout port that returns one map bit at a time. It reports whether the digit under the request address is zero, so the caller can refuse a decrement. It also gives the weighted token total.

Top module: `tok_counter`

## Requirements
- R1: After a synchronous reset, D4 holds 7 and every other digit holds 8. The total therefore reads 33352, and `pending_o` is 0.
- R2: Each stored field is a canonical thermometer code: k ones at the first-read positions, then zeros. `total_o` equals D4·4096 + D3·512 + D2·64 + D1·8 + D0 and is valid one cycle after the fields change.
- R3: `rd_bit_o` is valid one cycle after `rd_addr_i` is applied. It is 1 exactly when the address lies in a digit field at position p (0 = the field's lowest address) and p is less than that digit's value. Every other address reads 0, address 64 included.
- R4: A decrement request (`req_op_i` = 2'b01) at any address inside a digit lowers that digit by exactly one, whatever bit was addressed. A digit at zero stays at zero.
- R5: Address 64 selects D4 for every request type.
- R6: A refill request (`req_op_i` = 2'b10) at D4, D3, D2 or D1 sets the next lower digit to eight. At D0 it changes nothing.
- R7: A decrement-refill request (`req_op_i` = 2'b11) decrements the addressed digit and refills the next lower digit in the same commit. At D0 it only decrements.
- R8: The fields change only on a cycle with `pending_o` = 1, `commit_i` = 1 and `abort_i` = 0. An abort clears the pending update and leaves the fields as they were, and it wins when both strobes arrive together.
- R9: A request is ignored if it arrives while an update is pending, if its address is outside 64..103, or if its code is 2'b00.
- R10: `digit_zero_o` is valid one cycle after `req_addr_i` is applied. It is 1 exactly when that address selects a digit (64..103) whose value is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Update request strobe |
| req_op_i | input | 2 | 01 decrement, 10 refill lower digit, 11 both, 00 none |
| req_addr_i | input | 9 | Bit address of the request; also drives the zero query |
| commit_i | input | 1 | Completion strobe that writes the pending shadow into the fields |
| abort_i | input | 1 | Discards the pending update (models early power loss) |
| rd_addr_i | input | 9 | Readout bit address |
| rd_bit_o | output | 1 | Registered map bit at `rd_addr_i` |
| digit_zero_o | output | 1 | Registered flag: the digit at `req_addr_i` is zero |
| total_o | output | 16 | Registered weighted token total |
| pending_o | output | 1 | A computed update is waiting for commit or abort |

## Verification
A request is captured at one clock edge. A commit on the next edge writes the fields, and `total_o` reflects them one edge after that. The bench therefore applies the request, the strobe and its release on three successive falling edges and samples the total on the falling edge after the third rising edge. The readout bit and the zero flag are each one register away from their address inputs, so they are sampled one falling edge after the address is driven. Every check is made while no address or strobe is moving.

// File: rtl/tokctr_pkg.sv
package tokctr_pkg;
  typedef enum logic [1:0] {
    OP_NONE      = 2'b00,
    OP_DEC       = 2'b01,
    OP_REFILL    = 2'b10,
    OP_DECREFILL = 2'b11
  } tok_op_e;
endpackage

// File: rtl/tokctr_decode.sv
module tokctr_decode #(
  parameter int ADDR_W    = 9,
  parameter int BASE_ADDR = 65,
  parameter int NDIG      = 5,
  parameter int DIGW      = 8,
  parameter int TOP_W     = 7,
  parameter bit ALIAS_EN  = 1'b1,
  parameter int SEL_W     = 3,
  parameter int POS_W     = 3
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic [POS_W-1:0]  pos_o
);
  localparam int LOW_SPAN = DIGW * (NDIG - 1);

  int off;
  int grp;

  always_comb begin
    hit_o = 1'b0;
    sel_o = '0;
    pos_o = '0;
    off   = int'(addr_i) - BASE_ADDR;
    grp   = 0;
    if (ALIAS_EN && int'(addr_i) == BASE_ADDR - 1) begin
      hit_o = 1'b1;
      sel_o = SEL_W'(NDIG - 1);
    end else if (off >= 0 && off < TOP_W) begin
      hit_o = 1'b1;
      sel_o = SEL_W'(NDIG - 1);
      pos_o = POS_W'(off);
    end else if (off >= TOP_W && off < TOP_W + LOW_SPAN) begin
      grp   = (off - TOP_W) / DIGW;
      hit_o = 1'b1;
      sel_o = SEL_W'(NDIG - 2 - grp);
      pos_o = POS_W'((off - TOP_W) % DIGW);
    end
  end
endmodule

// File: rtl/tokctr_digit_next.sv
module tokctr_digit_next
  import tokctr_pkg::*;
#(
  parameter int DIGW  = 8,
  parameter int W     = 8,
  parameter int SEL_W = 3,
  parameter int IDX   = 0
) (
  input  logic [DIGW-1:0]  field_i,
  input  logic             hit_i,
  input  logic [SEL_W-1:0] sel_i,
  input  tok_op_e          op_i,
  output logic [DIGW-1:0]  next_o
);
  localparam logic [DIGW-1:0] FULL = DIGW'((1 << W) - 1);

  function automatic logic [DIGW-1:0] therm(input int k);
    therm = DIGW'((1 << k) - 1);
  endfunction

  int  cnt;
  logic dec_here;
  logic fill_here;

  always_comb begin
    cnt       = $countones(field_i);
    dec_here  = hit_i && (int'(sel_i) == IDX) &&
                (op_i == OP_DEC || op_i == OP_DECREFILL);
    fill_here = hit_i && (int'(sel_i) == IDX + 1) &&
                (op_i == OP_REFILL || op_i == OP_DECREFILL);
    if (fill_here)
      next_o = FULL;
    else if (dec_here)
      next_o = therm((cnt > 0) ? cnt - 1 : 0);
    else
      next_o = field_i;
  end
endmodule

// File: rtl/tokctr_readout.sv
module tokctr_readout #(
  parameter int NDIG  = 5,
  parameter int DIGW  = 8,
  parameter int TOP_W = 7,
  parameter int SEL_W = 3,
  parameter int POS_W = 3,
  parameter int TOT_W = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NDIG-1:0][DIGW-1:0] field_i,
  input  logic                      rd_hit_i,
  input  logic [SEL_W-1:0]          rd_sel_i,
  input  logic [POS_W-1:0]          rd_pos_i,
  input  logic                      q_hit_i,
  input  logic [SEL_W-1:0]          q_sel_i,
  output logic                      rd_bit_o,
  output logic                      zero_o,
  output logic [TOT_W-1:0]          total_o
);
  localparam int RADIX_SH = $clog2(DIGW);

  function automatic int max_total();
    int s;
    s = 0;
    for (int i = 0; i < NDIG; i++)
      s = s + ((i == NDIG - 1) ? TOP_W : DIGW) * (1 << (RADIX_SH * i));
    return s;
  endfunction

  localparam int MAX_TOT = max_total();

  logic [TOT_W-1:0] tot;

  always_comb begin
    tot = '0;
    for (int i = 0; i < NDIG; i++)
      tot = tot + (TOT_W'($countones(field_i[i])) << (RADIX_SH * i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_bit_o <= 1'b0;
      zero_o   <= 1'b0;
      total_o  <= '0;
    end else begin
      rd_bit_o <= rd_hit_i && field_i[rd_sel_i][rd_pos_i];
      zero_o   <= q_hit_i && (field_i[q_sel_i] == '0);
      total_o  <= tot;
    end
  end

  assert_rd_outside_R3: assert property (@(posedge clk) disable iff (rst)
    !rd_hit_i |=> !rd_bit_o)
    else $error("readout outside digit fields not zero");

  assert_zero_outside_R10: assert property (@(posedge clk) disable iff (rst)
    !q_hit_i |=> !zero_o)
    else $error("zero flag set for unmapped address");

  assert_total_max_R2: assert property (@(posedge clk) disable iff (rst)
    int'(total_o) <= MAX_TOT)
    else $error("token total above the largest encodable value");
endmodule

// File: rtl/tok_counter.sv
module tok_counter
  import tokctr_pkg::*;
#(
  parameter int ADDR_W    = 9,
  parameter int BASE_ADDR = 65,
  parameter int NDIG      = 5,
  parameter int DIGW      = 8,
  parameter int TOP_W     = 7,
  localparam int SEL_W    = $clog2(NDIG),
  localparam int POS_W    = $clog2(DIGW),
  localparam int TOT_W    = $clog2(DIGW) * (NDIG - 1) + $clog2(TOP_W + 1) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid_i,
  input  logic [1:0]        req_op_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              commit_i,
  input  logic              abort_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic              rd_bit_o,
  output logic              digit_zero_o,
  output logic [TOT_W-1:0]  total_o,
  output logic              pending_o
);
  function automatic logic [DIGW-1:0] full_of(input int i);
    full_of = (i == NDIG - 1) ? DIGW'((1 << TOP_W) - 1) : {DIGW{1'b1}};
  endfunction

  logic [NDIG-1:0][DIGW-1:0] field_q;
  logic [NDIG-1:0][DIGW-1:0] shadow_q;
  logic [NDIG-1:0][DIGW-1:0] next_field;
  logic                      pending_q;
  tok_op_e                   op_q;
  logic [SEL_W-1:0]          sel_q;

  tok_op_e          req_op;
  logic             q_hit;
  logic [SEL_W-1:0] q_sel;
  logic [POS_W-1:0] q_pos;
  logic             rd_hit;
  logic [SEL_W-1:0] rd_sel;
  logic [POS_W-1:0] rd_pos;
  logic             accept;
  logic             fire;

  assign req_op    = tok_op_e'(req_op_i);
  assign accept    = req_valid_i && !pending_q && q_hit && (req_op != OP_NONE);
  assign fire      = pending_q && commit_i && !abort_i;
  assign pending_o = pending_q;

  tokctr_decode #(
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .NDIG(NDIG), .DIGW(DIGW),
    .TOP_W(TOP_W), .ALIAS_EN(1'b1), .SEL_W(SEL_W), .POS_W(POS_W)
  ) u_req_dec (
    .addr_i(req_addr_i), .hit_o(q_hit), .sel_o(q_sel), .pos_o(q_pos)
  );

  tokctr_decode #(
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .NDIG(NDIG), .DIGW(DIGW),
    .TOP_W(TOP_W), .ALIAS_EN(1'b0), .SEL_W(SEL_W), .POS_W(POS_W)
  ) u_rd_dec (
    .addr_i(rd_addr_i), .hit_o(rd_hit), .sel_o(rd_sel), .pos_o(rd_pos)
  );

  for (genvar g = 0; g < NDIG; g++) begin : g_dig
    tokctr_digit_next #(
      .DIGW(DIGW), .W((g == NDIG - 1) ? TOP_W : DIGW), .SEL_W(SEL_W), .IDX(g)
    ) u_next (
      .field_i(field_q[g]), .hit_i(q_hit), .sel_i(q_sel), .op_i(req_op),
      .next_o(next_field[g])
    );

    assert_thermo_R2: assert property (@(posedge clk) disable iff (rst)
      (field_q[g] & DIGW'(field_q[g] + 1'b1)) == '0)
      else $error("digit field is not a thermometer code");
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NDIG; i++) begin
        field_q[i]  <= full_of(i);
        shadow_q[i] <= full_of(i);
      end
      pending_q <= 1'b0;
      op_q      <= OP_NONE;
      sel_q     <= '0;
    end else begin
      if (accept) begin
        shadow_q  <= next_field;
        pending_q <= 1'b1;
        op_q      <= req_op;
        sel_q     <= q_sel;
      end else if (pending_q && (commit_i || abort_i)) begin
        pending_q <= 1'b0;
      end
      if (fire)
        field_q <= shadow_q;
    end
  end

  tokctr_readout #(
    .NDIG(NDIG), .DIGW(DIGW), .TOP_W(TOP_W), .SEL_W(SEL_W), .POS_W(POS_W),
    .TOT_W(TOT_W)
  ) u_rd (
    .clk(clk), .rst(rst), .field_i(field_q),
    .rd_hit_i(rd_hit), .rd_sel_i(rd_sel), .rd_pos_i(rd_pos),
    .q_hit_i(q_hit), .q_sel_i(q_sel),
    .rd_bit_o(rd_bit_o), .zero_o(digit_zero_o), .total_o(total_o)
  );

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !fire |=> $stable(field_q))
    else $error("fields changed without a commit");

  assert_abort_R8: assert property (@(posedge clk) disable iff (rst)
    pending_q && abort_i |=> !pending_q && $stable(field_q))
    else $error("abort did not discard the pending update");

  assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (rst)
    pending_q && !commit_i && !abort_i |=> pending_q && $stable(shadow_q))
    else $error("shadow changed while an update was pending");

  assert_dec_one_R4: assert property (@(posedge clk) disable iff (rst)
    fire && op_q[0] && (field_q[sel_q] != '0) |=>
      $countones(field_q[sel_q]) == $countones($past(field_q[sel_q])) - 1)
    else $error("decrement did not lower the digit by one");

  assert_refill_R6: assert property (@(posedge clk) disable iff (rst)
    fire && op_q[1] && (sel_q != '0) |=> &field_q[sel_q - 1'b1])
    else $error("refill did not fill the lower digit");
endmodule

// File: tb/tok_counter_test.sv
`timescale 1ns/1ps
module tok_counter_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = 2'b00;
  logic [8:0]  req_addr = 9'd0;
  logic        commit = 1'b0;
  logic        abort = 1'b0;
  logic [8:0]  rd_addr = 9'd0;
  logic        rd_bit;
  logic        digit_zero;
  logic [15:0] total;
  logic        pending;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tok_counter uut (
    .clk(clk), .rst(rst), .req_valid_i(req_valid), .req_op_i(req_op),
    .req_addr_i(req_addr), .commit_i(commit), .abort_i(abort),
    .rd_addr_i(rd_addr), .rd_bit_o(rd_bit), .digit_zero_o(digit_zero),
    .total_o(total), .pending_o(pending)
  );

  // row: {mode[1:0] (0 commit, 1 abort, 2 both), op[1:0], addr[8:0], expected total[15:0]}
  localparam logic [28:0] VEC [12] = '{
    {2'd0, 2'd1, 9'd96,  16'd33351},  // R4 decrement D0 at its first bit
    {2'd0, 2'd1, 9'd103, 16'd33350},  // R4 decrement D0 at its last bit
    {2'd0, 2'd1, 9'd64,  16'd29254},  // R5 status address decrements D4
    {2'd1, 2'd1, 9'd72,  16'd29254},  // R8 aborted decrement of D3
    {2'd0, 2'd2, 9'd88,  16'd29256},  // R6 refill from D1 sets D0 to 8
    {2'd0, 2'd3, 9'd80,  16'd29192},  // R7 D2 down, D1 already 8
    {2'd0, 2'd1, 9'd88,  16'd29184},  // R4 D1 down to 7
    {2'd0, 2'd3, 9'd80,  16'd29128},  // R7 D2 down, D1 back to 8
    {2'd0, 2'd2, 9'd96,  16'd29128},  // R6 refill at D0 has no effect
    {2'd0, 2'd3, 9'd100, 16'd29127},  // R7 decrement-refill at D0 only decrements
    {2'd0, 2'd1, 9'd65,  16'd25031},  // R4 D4 down to 5
    {2'd0, 2'd1, 9'd40,  16'd25031}   // R9 address outside the counter ignored
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // request on one falling edge, strobe on the next, release, then wait for total
  task automatic do_op(input logic [1:0] op, input int addr, input int mode);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = 9'(addr);
    @(negedge clk);
    req_valid = 1'b0;
    commit = (mode != 1); abort = (mode != 0);
    @(negedge clk);
    commit = 1'b0; abort = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd_chk(input string tag, input int addr, input int exp);
    @(negedge clk);
    rd_addr = 9'(addr);
    @(negedge clk);
    chk(tag, int'(rd_bit), exp);
  endtask

  task automatic zero_chk(input string tag, input int addr, input int exp);
    @(negedge clk);
    req_addr = 9'(addr);
    @(negedge clk);
    chk(tag, int'(digit_zero), exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rd_addr = 9'd71; req_addr = 9'd103;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 total after reset", int'(total), 33352);
    chk("R1 pending after reset", int'(pending), 0);
    chk("R1 D4 top bit after reset", int'(rd_bit), 1);
    chk("R1 D0 not zero after reset", int'(digit_zero), 0);

    for (int i = 0; i < 12; i++) begin
      do_op(VEC[i][26:25], int'(VEC[i][24:16]), int'(VEC[i][28:27]));
      chk($sformatf("vector %0d total", i), int'(total), int'(VEC[i][15:0]));
    end
    chk("R9 no pending after ignored request", int'(pending), 0);

    // digits now 5 8 6 8 7; drain to octal 00500
    for (int i = 0; i < 5; i++) do_op(2'd1, 65, 0);
    for (int i = 0; i < 8; i++) do_op(2'd1, 72, 0);
    do_op(2'd1, 80, 0);
    for (int i = 0; i < 8; i++) do_op(2'd1, 88, 0);
    for (int i = 0; i < 7; i++) do_op(2'd1, 96, 0);
    chk("R2 octal 00500", int'(total), 320);

    do_op(2'd1, 81, 0); chk("R4 worked case 00400", int'(total), 256);
    do_op(2'd2, 84, 0); chk("R6 worked case 00480", int'(total), 320);
    do_op(2'd1, 93, 0); chk("R4 worked case 00470", int'(total), 312);
    do_op(2'd2, 90, 0); chk("R6 worked case 00478", int'(total), 320);
    do_op(2'd1, 99, 0); chk("R4 worked case 00477", int'(total), 319);

    zero_chk("R10 D4 zero", 65, 1);
    zero_chk("R10 status address sees D4 zero", 64, 1);
    zero_chk("R10 D3 zero", 79, 1);
    zero_chk("R10 D2 nonzero", 80, 0);
    zero_chk("R10 unmapped address", 40, 0);

    do_op(2'd1, 68, 0); chk("R4 decrement of zero digit saturates", int'(total), 319);

    rd_chk("R3 D1 position 6", 94, 1);
    rd_chk("R3 D1 position 7", 95, 0);
    rd_chk("R3 D0 position 6", 102, 1);
    rd_chk("R3 D0 position 7", 103, 0);
    rd_chk("R3 D2 position 3", 83, 1);
    rd_chk("R3 D2 position 4", 84, 0);
    rd_chk("R3 status address reads 0", 64, 0);

    do_op(2'd2, 70, 0); chk("R6 refill from D4 fills D3", int'(total), 4415);
    rd_chk("R2 refilled D3 canonical last bit", 79, 1);

    // second request while pending is ignored; nothing moves before commit
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'd1; req_addr = 9'd96;
    @(negedge clk);
    req_op = 2'd3; req_addr = 9'd80;
    @(negedge clk);
    chk("R9 pending held", int'(pending), 1);
    req_valid = 1'b0;
    @(negedge clk);
    chk("R8 total unchanged before commit", int'(total), 4415);
    commit = 1'b1;
    @(negedge clk);
    commit = 1'b0;
    @(negedge clk);
    chk("R9 only the first request applied", int'(total), 4414);

    do_op(2'd1, 96, 2); chk("R8 abort wins over commit", int'(total), 4414);
    chk("R8 pending cleared by abort", int'(pending), 0);

    finish_run();
  end
endmodule